// File: doc/BRIEF.md
# Interrupt Line Router with Pending Latch

This block sits at the input edge of an interrupt controller. It receives one flat vector of interrupt wires from the rest of the chip and decides, for each wire, which bank it belongs to. Low-numbered wires are shared interrupts. Each shared wire at position i is held as shared interrupt ID i + 32. The wires above the shared range come in groups of 32, one group per processor. Inside a group, the offset is the local ID. Only local IDs 16 to 31 may come from a wire. IDs 0 to 15 are reserved for software-generated interrupts, and a wire aimed at them, or at a processor that is not configured, is an integration fault.

For every legal interrupt the block records the last sampled level. For interrupts configured as edge-triggered, it latches a pending bit on each rising edge. A latched bit stays set until software clears it through a per-interrupt clear vector. For level-configured interrupts, the pending output follows the stored level, ORed with any bit still latched. When at least one line really changes level, the block raises a one-cycle update mask. The mask has one bit for the shared bank and one bit for each processor bank, so the downstream arbitration logic knows which banks to re-evaluate.

Top module: `irq_line_router`

## Requirements
- R1: Wire i, for i below NUM_IRQ-32, drives bit i of the shared bank (interrupt ID i+32). A level change on it sets update mask bit 0.
- R2: Wire NUM_IRQ-32 + 32*c + k, with k from 16 to 31 and c below NUM_CPU, drives bit 32*c+k of `ppi_pend`. A level change on it sets update mask bit c+1.
- R3: A wire whose local ID k is below 16 never changes any pending output or the update mask. While such a wire is high, `wire_err` is 1 one cycle later.
- R4: A wire whose processor number c is NUM_CPU or higher changes no state. While such a wire is high, `wire_err` is 1 one cycle later.
- R5: A cycle in which no legal line differs from its stored level produces an all-zero update mask and leaves every pending output unchanged, apart from clears.
- R6: For a level-configured interrupt, the pending output equals the level sampled at the last clock edge, ORed with any latched bit.
- R7: A 0-to-1 change on an edge-configured interrupt latches its pending bit. The pending output shows it one cycle after the sampling edge.
- R8: A 1-to-0 change never clears a latched bit. Only a 1 on the matching clear bit clears it. If a new rising edge and a clear arrive in the same cycle, the latched bit stays set.
- R9: The update mask is valid for exactly one cycle, in the cycle after the sampling edge. Changes in several banks in the same cycle set all of their mask bits together.
- R10: After reset, all levels, latched bits, edge configuration bits, the update mask and `wire_err` are 0, so every interrupt starts level-sensitive.
- R11: A cycle with `cfg_we` = 1 loads both edge configuration vectors, where 1 means edge-triggered. The new configuration governs latching from the next sampling edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | IN_W | Flat vector of interrupt wires |
| cfg_we | input | 1 | Load the edge configuration vectors |
| cfg_spi_edge | input | NUM_IRQ-32 | Edge (1) or level (0) configuration for each shared interrupt |
| cfg_ppi_edge | input | NUM_CPU*32 | Edge or level configuration for each private interrupt, bank by bank |
| clr_spi | input | NUM_IRQ-32 | Clear the latched pending bit of each shared interrupt |
| clr_ppi | input | NUM_CPU*32 | Clear the latched pending bit of each private interrupt |
| spi_pend | output | NUM_IRQ-32 | Pending state of the shared bank; bit i is ID i+32 |
| ppi_pend | output | NUM_CPU*32 | Pending state of the private banks; bits 32c..32c+31 belong to processor c |
| upd_mask | output | NUM_CPU+1 | One-cycle strobe; bit 0 marks the shared bank and bit c+1 marks processor c |
| wire_err | output | 1 | An illegal wire was high at the last sampling edge |

## Verification
Two functions can act on the same interrupt in the same clock: a rising edge latching a pending bit, and a software clear of that bit. The bench provokes this by raising an edge-configured shared line in the same cycle that its clear bit is driven. The result is judged as a latch that stays set. The following cycle, which lowers the line and clears again, must then empty the bit. Random traffic later mixes lines, clears and reconfiguration freely, and every cycle is compared against an independent model of this precedence rule.

// File: rtl/irq_line_router.sv
module irq_line_router #(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  parameter int IN_W    = 160
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IN_W-1:0]         irq_in,
  input  logic                    cfg_we,
  input  logic [NUM_IRQ-33:0]     cfg_spi_edge,
  input  logic [NUM_CPU*32-1:0]   cfg_ppi_edge,
  input  logic [NUM_IRQ-33:0]     clr_spi,
  input  logic [NUM_CPU*32-1:0]   clr_ppi,
  output logic [NUM_IRQ-33:0]     spi_pend,
  output logic [NUM_CPU*32-1:0]   ppi_pend,
  output logic [NUM_CPU:0]        upd_mask,
  output logic                    wire_err
);
  localparam int NSPI  = NUM_IRQ - 32;
  localparam int LOC_W = NUM_CPU * 32;
  localparam int EXTRA = IN_W - NSPI - LOC_W;

  function automatic logic [LOC_W-1:0] legal_mask();
    logic [LOC_W-1:0] m;
    m = '0;
    for (int j = 0; j < LOC_W; j++) m[j] = (j % 32) >= 16;
    return m;
  endfunction

  localparam logic [LOC_W-1:0] LEGAL = legal_mask();

  logic [NSPI-1:0]  spi_in, spi_lvl, spi_edge, spi_pl, spi_chg;
  logic [LOC_W-1:0] ppi_raw, ppi_in, ppi_lvl, ppi_edge, ppi_pl, ppi_chg;
  logic [NUM_CPU:0] bank_chg;
  logic             extra_hit, bad_now;

  assign spi_in  = irq_in[NSPI-1:0];
  assign ppi_raw = irq_in[NSPI +: LOC_W];
  assign ppi_in  = ppi_raw & LEGAL;
  assign spi_chg = spi_in ^ spi_lvl;
  assign ppi_chg = ppi_in ^ ppi_lvl;

  if (EXTRA > 0) begin : g_extra
    assign extra_hit = |irq_in[IN_W-1:NSPI+LOC_W];
  end else begin : g_noextra
    assign extra_hit = 1'b0;
  end

  assign bad_now = extra_hit | (|(ppi_raw & ~LEGAL));

  assign bank_chg[0] = |spi_chg;
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    assign bank_chg[c+1] = |ppi_chg[c*32 +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_lvl  <= '0;
      spi_edge <= '0;
      spi_pl   <= '0;
      ppi_lvl  <= '0;
      ppi_edge <= '0;
      ppi_pl   <= '0;
      upd_mask <= '0;
      wire_err <= 1'b0;
    end else begin
      spi_lvl  <= spi_in;
      ppi_lvl  <= ppi_in;
      spi_pl   <= (spi_pl & ~clr_spi) | (spi_chg & spi_in & spi_edge);
      ppi_pl   <= (ppi_pl & ~clr_ppi) | (ppi_chg & ppi_in & ppi_edge);
      upd_mask <= bank_chg;
      wire_err <= bad_now;
      if (cfg_we) begin
        spi_edge <= cfg_spi_edge;
        ppi_edge <= cfg_ppi_edge & LEGAL;
      end
    end
  end

  assign spi_pend = spi_pl | (spi_lvl & ~spi_edge);
  assign ppi_pend = ppi_pl | (ppi_lvl & ~ppi_edge);
endmodule

// File: rtl/irq_line_router_chk.sv
module irq_line_router_chk #(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  parameter int IN_W    = 160
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [IN_W-1:0]       irq_in,
  input logic [NUM_IRQ-33:0]   clr_spi,
  input logic [NUM_IRQ-33:0]   spi_pend,
  input logic [NUM_IRQ-33:0]   spi_edge,
  input logic [NUM_CPU:0]      upd_mask,
  input logic                  wire_err
);
  localparam int NSPI  = NUM_IRQ - 32;
  localparam int LOC_W = NUM_CPU * 32;
  localparam int EXTRA = IN_W - NSPI - LOC_W;

  function automatic logic [LOC_W-1:0] legal_mask();
    logic [LOC_W-1:0] m;
    m = '0;
    for (int j = 0; j < LOC_W; j++) m[j] = (j % 32) >= 16;
    return m;
  endfunction

  localparam logic [LOC_W-1:0] LEGAL = legal_mask();

  logic [1:0]       age;
  logic [NSPI-1:0]  spi_w;
  logic [LOC_W-1:0] loc_w;
  logic             bad_local, bad_cpu;

  assign spi_w     = irq_in[NSPI-1:0];
  assign loc_w     = irq_in[NSPI +: LOC_W];
  assign bad_local = |(loc_w & ~LEGAL);

  if (EXTRA > 0) begin : g_extra
    assign bad_cpu = |irq_in[IN_W-1:NSPI+LOC_W];
  end else begin : g_noextra
    assign bad_cpu = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(irq_in) == $past(irq_in, 2)) |-> upd_mask == '0); // R5

  AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 |-> ((spi_pend & $past(spi_w) & ~$past(spi_w, 2) & $past(spi_edge))
                     == ($past(spi_w) & ~$past(spi_w, 2) & $past(spi_edge)))); // R7

  AST_HOLD_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    age != 2'd0 |-> ((spi_pend & $past(spi_pend & spi_edge & ~clr_spi))
                     == $past(spi_pend & spi_edge & ~clr_spi))); // R8

  AST_BAD_LOCAL_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(bad_local)) |-> wire_err); // R3

  AST_BAD_CPU_NUM: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(bad_cpu)) |-> wire_err); // R4
endmodule

bind irq_line_router irq_line_router_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .IN_W(IN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_spi(clr_spi),
  .spi_pend(spi_pend), .spi_edge(spi_edge), .upd_mask(upd_mask), .wire_err(wire_err)
);

// File: tb/test_irq_line_router.sv
module test_irq_line_router;
  localparam int NUM_IRQ = 96;
  localparam int NUM_CPU = 2;
  localparam int IN_W    = 160;
  localparam int NSPI    = NUM_IRQ - 32;
  localparam int LOC_W   = NUM_CPU * 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [IN_W-1:0]   irq_in;
  logic              cfg_we;
  logic [NSPI-1:0]   cfg_spi_edge, clr_spi, spi_pend;
  logic [LOC_W-1:0]  cfg_ppi_edge, clr_ppi, ppi_pend;
  logic [NUM_CPU:0]  upd_mask;
  logic              wire_err;

  irq_line_router #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .IN_W(IN_W)) i_irq_line_router (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_spi_edge(cfg_spi_edge), .cfg_ppi_edge(cfg_ppi_edge),
    .clr_spi(clr_spi), .clr_ppi(clr_ppi), .spi_pend(spi_pend),
    .ppi_pend(ppi_pend), .upd_mask(upd_mask), .wire_err(wire_err)
  );

  typedef struct {
    string            tag;
    logic [NSPI-1:0]  spi;
    logic [LOC_W-1:0] ppi;
    logic [NUM_CPU:0] msk;
    logic             err;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  logic [NSPI-1:0]  m_sl, m_sp, m_se;
  logic [LOC_W-1:0] m_pl, m_pp, m_pe, lm;

  task automatic cmp(string tag, string f, logic [63:0] a, logic [63:0] x);
    checks++;
    if (a !== x) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, f, a, x);
    end
  endtask

  function automatic logic [IN_W-1:0] pl(int c, int k);
    logic [IN_W-1:0] v;
    v = '0;
    v[NSPI + c*32 + k] = 1'b1;
    return v;
  endfunction

  task automatic step(string tag, logic [IN_W-1:0] lines,
                      logic [NSPI-1:0] cs = '0, logic [LOC_W-1:0] cp = '0,
                      logic we = 1'b0, logic [NSPI-1:0] es = '0,
                      logic [LOC_W-1:0] ep = '0);
    exp_t e;
    logic [NSPI-1:0]  sin;
    logic [LOC_W-1:0] raw, pin, pchg;
    @(negedge clk);
    irq_in = lines; clr_spi = cs; clr_ppi = cp;
    cfg_we = we; cfg_spi_edge = es; cfg_ppi_edge = ep;
    sin  = lines[NSPI-1:0];
    raw  = lines[NSPI +: LOC_W];
    pin  = raw & lm;
    pchg = pin ^ m_pl;
    e.tag = tag;
    e.err = (|(raw & ~lm)) | (|lines[IN_W-1:NSPI+LOC_W]);
    e.msk[0] = |(sin ^ m_sl);
    for (int c = 0; c < NUM_CPU; c++) e.msk[c+1] = |pchg[c*32 +: 32];
    m_sp = (m_sp & ~cs) | (sin & ~m_sl & m_se);
    m_pp = (m_pp & ~cp) | (pin & ~m_pl & m_pe);
    m_sl = sin;
    m_pl = pin;
    if (we) begin
      m_se = es;
      m_pe = ep & lm;
    end
    e.spi = m_sp | (m_sl & ~m_se);
    e.ppi = m_pp | (m_pl & ~m_pe);
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.tag, "spi_pend", 64'(spi_pend), 64'(e.spi));
        cmp(e.tag, "ppi_pend", 64'(ppi_pend), 64'(e.ppi));
        cmp(e.tag, "upd_mask", 64'(upd_mask), 64'(e.msk));
        cmp(e.tag, "wire_err", 64'(wire_err), 64'(e.err));
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin : watchdog
    #(20ns * 150000);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : driver
    logic [IN_W-1:0]  L;
    logic [NSPI-1:0]  es;
    logic [LOC_W-1:0] ep;
    for (int j = 0; j < LOC_W; j++) lm[j] = (j % 32) >= 16;
    m_sl = '0; m_sp = '0; m_se = '0; m_pl = '0; m_pp = '0; m_pe = '0;
    rst_n = 1'b0; irq_in = '0; cfg_we = 1'b0; cfg_spi_edge = '0; cfg_ppi_edge = '0;
    clr_spi = '0; clr_ppi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    cmp("R10", "spi_pend", 64'(spi_pend), 64'd0);
    cmp("R10", "ppi_pend", 64'(ppi_pend), 64'd0);
    cmp("R10", "upd_mask", 64'(upd_mask), 64'd0);
    L = '0;
    step("R10", L);
    // R1: shared lines at both ends of the bank, level-configured
    L[0] = 1'b1; L[NSPI-1] = 1'b1;
    step("R1", L);
    step("R5", L);
    L[0] = 1'b0;
    step("R6", L);
    L[NSPI-1] = 1'b0;
    step("R6", L);
    // R11: shared 5 and cpu1 local 20 become edge-triggered
    es = '0; es[5] = 1'b1;
    ep = '0; ep[32+20] = 1'b1;
    step("R11", L, '0, '0, 1'b1, es, ep);
    L[5] = 1'b1;
    step("R7", L);
    L[5] = 1'b0;
    step("R8", L);
    step("R8", L, NSPI'(1) << 5);
    // R8: rising edge and clear in the same cycle, latch wins
    L[5] = 1'b1;
    step("R8", L, NSPI'(1) << 5);
    L[5] = 1'b0;
    step("R8", L, NSPI'(1) << 5);
    // R2: private lines in both processor banks
    L = L | pl(0, 16) | pl(1, 31);
    step("R2", L);
    L = '0;
    step("R2", L);
    L = pl(1, 20);
    step("R7", L);
    L = '0;
    step("R8", L);
    step("R8", L, '0, LOC_W'(1) << (32+20));
    // R3: wire aimed at a software-generated ID
    L = pl(0, 3);
    step("R3", L);
    L = '0;
    step("R3", L);
    // R4: wire aimed at a processor beyond the configured count
    L = pl(NUM_CPU, 18);
    step("R4", L);
    L = '0;
    step("R4", L);
    // R9: three banks change together
    L[10] = 1'b1;
    L = L | pl(0, 17) | pl(1, 25);
    step("R9", L);
    step("R9", L);
    L = '0;
    step("R9", L);
    // R6: random mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [IN_W-1:0]  r;
      logic [NSPI-1:0]  cs;
      logic [LOC_W-1:0] cp;
      logic             we;
      for (int w = 0; w < IN_W; w += 32) r[w +: 32] = $urandom;
      r[IN_W-1:NSPI+LOC_W] = (n % 7 == 0) ? r[IN_W-1:NSPI+LOC_W] : '0;
      r[NSPI +: LOC_W] = (n % 5 == 0) ? r[NSPI +: LOC_W] : (r[NSPI +: LOC_W] & lm);
      cs = {$urandom, $urandom} & {$urandom, $urandom};
      cp = {$urandom, $urandom} & {$urandom, $urandom};
      we = (n % 16 == 3);
      es = {$urandom, $urandom};
      ep = {$urandom, $urandom};
      step("R6", r, cs, cp, we, es, ep);
    end
    repeat (3) @(posedge clk);
    #6;
    summary();
    $finish;
  end
endmodule